// File: doc/BRIEF.md
# Conditional Branch Decision and Program Counter Unit

This unit decides, for each branch instruction presented by the decoder, whether control transfers to a new address. It reads a 4-bit condition code and the four arithmetic flags (zero, overflow, negative, carry). It combines them into one "taken" signal. That signal selects between loading a 16-bit jump target and advancing the program counter past the current instruction's bytes.

The target comes either from an absolute address supplied with the instruction or from the 16-bit register pair that holds a pointer. A select input picks between the two. Besides an unconditional jump, every flag has a taken-when-set and a taken-when-clear test. A composite "greater than zero" test is taken only when both the zero flag and the negative flag are clear. A registered copy of the decision is also provided, one cycle late, for logic that needs to know the previous edge loaded a target.

Top module: `brc_branch_unit`

## Requirements
- R1: A synchronous active-high reset sets the program counter to 0x0000 and the registered decision to 0.
- R2: With a branch valid, condition code 0 (always) is taken whatever the flags are.
- R3: Codes 1, 2, 3 and 4 are taken exactly when Z, O, N and C respectively are 1.
- R4: Codes 5, 6, 7 and 8 are taken exactly when Z, O, N and C respectively are 0. Code 7 is the positive-or-zero test.
- R5: Code 9 (greater than zero) is taken exactly when Z is 0 and N is 0.
- R6: Codes 10 through 15 are never taken.
- R7: While the branch-valid input is low, the decision is 0 for every code and flag value.
- R8: When the decision is 1, the program counter holds the selected target after the next clock edge. This takes priority over incrementing.
- R9: Target select 0 takes the absolute address input; select 1 takes the register-pair input.
- R10: When the decision is 0 and the increment enable is 1, the program counter advances by the 2-bit step input at the edge, wrapping modulo 2^16.
- R11: When the decision is 0 and the increment enable is 0, the program counter keeps its value.
- R12: The registered decision output equals the decision of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | A branch instruction is being resolved this cycle |
| cond_code | input | 4 | Condition code (0 always, 1-4 flag set, 5-8 flag clear, 9 greater than zero) |
| flags | input | 4 | Flags {Z, O, N, C}, Z in bit 3, C in bit 0 |
| tgt_sel | input | 1 | 0: absolute target, 1: register-pair target |
| abs_target | input | 16 | Absolute jump address |
| pair_target | input | 16 | Jump address from the register pair |
| inc_en | input | 1 | Advance the program counter when not branching |
| inc_step | input | 2 | Number of bytes to advance |
| branch_taken | output | 1 | Combinational branch decision |
| take_q | output | 1 | Decision registered at the last edge |
| pc | output | 16 | Program counter |

## Verification
The bench runs every condition code against all sixteen flag combinations. A design that swapped two flag positions, or inverted a set/clear pair, fails there. A greater-than-zero test built from only one flag is taken for a negative or a zero result and is caught. The unused codes and a low valid input are checked to stay not taken. A decoder that aliased codes 10-15 onto real conditions would jump spuriously.

Random cycles mix taken branches, increments and holds. They expose a design that gives the increment priority over a load or picks the wrong target source. Directed steps push the counter through 0xFFFF to check wrap-around, and assert reset in the middle of a run.

// File: rtl/brc_pkg.sv
package brc_pkg;

    localparam int COND_W = 4;
    localparam int NUM_FLAGS = 4;

    typedef enum logic [COND_W-1:0] {
        COND_ALWAYS  = 4'd0,
        COND_Z_SET   = 4'd1,
        COND_O_SET   = 4'd2,
        COND_N_SET   = 4'd3,
        COND_C_SET   = 4'd4,
        COND_Z_CLR   = 4'd5,
        COND_O_CLR   = 4'd6,
        COND_N_CLR   = 4'd7,
        COND_C_CLR   = 4'd8,
        COND_GT_ZERO = 4'd9
    } cond_e;

    typedef struct packed {
        logic z;
        logic o;
        logic n;
        logic c;
    } flags_t;

    localparam logic [COND_W-1:0] SET_BASE = COND_Z_SET;
    localparam logic [COND_W-1:0] CLR_BASE = COND_Z_CLR;

    // flag index 0 is Z, 3 is C (matches the set/clear code order)
    function automatic logic flag_at(flags_t f, int idx);
        logic [NUM_FLAGS-1:0] v;
        v = f;
        return v[NUM_FLAGS-1-idx];
    endfunction

endpackage

// File: rtl/brc_cond_eval.sv
module brc_cond_eval
    import brc_pkg::*;
(
    input  logic [COND_W-1:0] code,
    input  flags_t            flags,
    output logic              hit
);

    logic [NUM_FLAGS-1:0] set_hit;
    logic [NUM_FLAGS-1:0] clr_hit;
    logic                 always_hit;
    logic                 gt_hit;

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        localparam logic [COND_W-1:0] SET_CODE = SET_BASE + COND_W'(i);
        localparam logic [COND_W-1:0] CLR_CODE = CLR_BASE + COND_W'(i);
        assign set_hit[i] = (code == SET_CODE) &&  flag_at(flags, i);
        assign clr_hit[i] = (code == CLR_CODE) && !flag_at(flags, i);
    end

    assign always_hit = (code == COND_ALWAYS);
    assign gt_hit     = (code == COND_GT_ZERO) && !flags.z && !flags.n;

    assign hit = always_hit || gt_hit || (|set_hit) || (|clr_hit);

endmodule

// File: rtl/brc_target_mux.sv
module brc_target_mux #(
    parameter int ADDR_W = 16
) (
    input  logic              sel_pair,
    input  logic [ADDR_W-1:0] abs_addr,
    input  logic [ADDR_W-1:0] pair_addr,
    output logic [ADDR_W-1:0] target
);

    always_comb begin
        target = sel_pair ? pair_addr : abs_addr;
    end

endmodule

// File: rtl/brc_pc_reg.sv
module brc_pc_reg #(
    parameter int ADDR_W = 16,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              inc_en,
    input  logic [STEP_W-1:0] inc_step,
    output logic [ADDR_W-1:0] pc_q,
    output logic              load_q
);

    logic [ADDR_W-1:0] pc_next;

    always_comb begin
        if (load) begin
            pc_next = load_addr;
        end else if (inc_en) begin
            pc_next = pc_q + ADDR_W'(inc_step);
        end else begin
            pc_next = pc_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q   <= '0;
            load_q <= 1'b0;
        end else begin
            pc_q   <= pc_next;
            load_q <= load;
        end
    end

endmodule

// File: rtl/brc_branch_unit.sv
module brc_branch_unit
    import brc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              br_valid,
    input  logic [3:0]        cond_code,
    input  logic [3:0]        flags,
    input  logic              tgt_sel,
    input  logic [ADDR_W-1:0] abs_target,
    input  logic [ADDR_W-1:0] pair_target,
    input  logic              inc_en,
    input  logic [STEP_W-1:0] inc_step,
    output logic              branch_taken,
    output logic              take_q,
    output logic [ADDR_W-1:0] pc
);

    flags_t            flag_s;
    logic              cond_hit;
    logic [ADDR_W-1:0] target;

    assign flag_s = flags_t'(flags);

    brc_cond_eval u_cond (
        .code  (cond_code),
        .flags (flag_s),
        .hit   (cond_hit)
    );

    assign branch_taken = br_valid && cond_hit;

    brc_target_mux #(.ADDR_W(ADDR_W)) u_mux (
        .sel_pair  (tgt_sel),
        .abs_addr  (abs_target),
        .pair_addr (pair_target),
        .target    (target)
    );

    brc_pc_reg #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .load      (branch_taken),
        .load_addr (target),
        .inc_en    (inc_en),
        .inc_step  (inc_step),
        .pc_q      (pc),
        .load_q    (take_q)
    );

endmodule

// File: rtl/brc_branch_unit_chk.sv
module brc_branch_unit_chk #(
    parameter int ADDR_W = 16,
    parameter int STEP_W = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              br_valid,
    input logic [3:0]        cond_code,
    input logic [3:0]        flags,
    input logic              tgt_sel,
    input logic [ADDR_W-1:0] abs_target,
    input logic [ADDR_W-1:0] pair_target,
    input logic              inc_en,
    input logic [STEP_W-1:0] inc_step,
    input logic              branch_taken,
    input logic              take_q,
    input logic [ADDR_W-1:0] pc
);

    p_abs_load_r9: assert property (@(posedge clk) disable iff (rst)
        branch_taken && !tgt_sel |=> pc == $past(abs_target));

    p_pair_load_r8: assert property (@(posedge clk) disable iff (rst)
        branch_taken && tgt_sel |=> pc == $past(pair_target));

    p_advance_r10: assert property (@(posedge clk) disable iff (rst)
        !branch_taken && inc_en |=> pc == ADDR_W'($past(pc) + ADDR_W'($past(inc_step))));

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        !branch_taken && !inc_en |=> $stable(pc));

    p_take_q_r12: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> take_q == $past(branch_taken));

    p_unused_code_r6: assert property (@(posedge clk) disable iff (rst)
        cond_code >= 4'd10 |-> !branch_taken);

    p_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
        !br_valid |-> !branch_taken);

    p_gt_zero_r5: assert property (@(posedge clk) disable iff (rst)
        br_valid && cond_code == 4'd9 |-> branch_taken == (!flags[3] && !flags[1]));

endmodule

bind brc_branch_unit brc_branch_unit_chk #(.ADDR_W(ADDR_W), .STEP_W(STEP_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .br_valid     (br_valid),
    .cond_code    (cond_code),
    .flags        (flags),
    .tgt_sel      (tgt_sel),
    .abs_target   (abs_target),
    .pair_target  (pair_target),
    .inc_en       (inc_en),
    .inc_step     (inc_step),
    .branch_taken (branch_taken),
    .take_q       (take_q),
    .pc           (pc)
);

// File: tb/brc_branch_unit_tb_top.sv
module brc_branch_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        br_valid;
    logic [3:0]  cond_code;
    logic [3:0]  flags;
    logic        tgt_sel;
    logic [15:0] abs_target;
    logic [15:0] pair_target;
    logic        inc_en;
    logic [1:0]  inc_step;
    logic        branch_taken;
    logic        take_q;
    logic [15:0] pc;

    int n_tests = 0;
    int n_fail  = 0;
    logic [15:0] pc_exp;
    logic        tq_exp;
    logic        seed_init;

    always #10 clk = ~clk;

    brc_branch_unit dut_i (
        .clk          (clk),
        .rst          (rst),
        .br_valid     (br_valid),
        .cond_code    (cond_code),
        .flags        (flags),
        .tgt_sel      (tgt_sel),
        .abs_target   (abs_target),
        .pair_target  (pair_target),
        .inc_en       (inc_en),
        .inc_step     (inc_step),
        .branch_taken (branch_taken),
        .take_q       (take_q),
        .pc           (pc)
    );

    // flags = {Z, O, N, C}
    function automatic logic model_take(logic v, logic [3:0] code, logic [3:0] f);
        logic z, o, n, c;
        z = f[3]; o = f[2]; n = f[1]; c = f[0];
        if (!v) return 1'b0;
        case (code)
            4'd0: return 1'b1;
            4'd1: return z;
            4'd2: return o;
            4'd3: return n;
            4'd4: return c;
            4'd5: return !z;
            4'd6: return !o;
            4'd7: return !n;
            4'd8: return !c;
            4'd9: return !z && !n;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string code_req(logic v, logic [3:0] code);
        if (!v) return "R7";
        if (code == 4'd0) return "R2";
        if (code <= 4'd4) return "R3";
        if (code <= 4'd8) return "R4";
        if (code == 4'd9) return "R5";
        return "R6";
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // drive one cycle of inputs at negedge, check the decision, advance the model,
    // then check registered outputs at the following negedge
    task automatic step(logic v, logic [3:0] code, logic [3:0] f, logic sel,
                        logic [15:0] a, logic [15:0] p, logic ie, logic [1:0] st);
        logic t;
        string pc_req;
        br_valid = v; cond_code = code; flags = f; tgt_sel = sel;
        abs_target = a; pair_target = p; inc_en = ie; inc_step = st;
        #1;
        t = model_take(v, code, f);
        check(code_req(v, code), 32'(branch_taken), 32'(t));
        if (t) begin
            pc_req = sel ? "R9" : "R8";
            pc_exp = sel ? p : a;
        end else if (ie) begin
            pc_req = "R10";
            pc_exp = pc_exp + 16'(st);
        end else begin
            pc_req = "R11";
        end
        tq_exp = t;
        @(negedge clk);
        check(pc_req, 32'(pc), 32'(pc_exp));
        check("R12", 32'(take_q), 32'(tq_exp));
    endtask

    task automatic do_reset();
        rst = 1'b1;
        br_valid = 1'b1; cond_code = 4'd0; tgt_sel = 1'b0;
        abs_target = 16'hBEEF; inc_en = 1'b1; inc_step = 2'd1;
        @(negedge clk);
        @(negedge clk);
        check("R1", 32'(pc), 32'h0);
        check("R1", 32'(take_q), 32'h0);
        rst = 1'b0;
        br_valid = 1'b0; inc_en = 1'b0;
        pc_exp = 16'h0;
        tq_exp = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        seed_init = 1'($urandom(32'd4242));
        rst = 1'b1;
        br_valid = 1'b0; cond_code = 4'd0; flags = 4'd0; tgt_sel = 1'b0;
        abs_target = 16'h0; pair_target = 16'h0; inc_en = 1'b0; inc_step = 2'd0;
        @(negedge clk);
        do_reset();

        // exhaustive decision table: R2 R3 R4 R5 R6
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                step(1'b1, 4'(c), 4'(f), 1'(f), 16'(c * 16'h111 + f),
                     16'(16'hF000 ^ (c << 4) ^ f), 1'b1, 2'(c));
            end
        end

        // branch valid low: R7
        for (int c = 0; c < 16; c++)
            step(1'b0, 4'(c), 4'(c), 1'b0, 16'h1234, 16'h4321, 1'b0, 2'd3);

        // wrap past 0xFFFF: R10
        step(1'b1, 4'd0, 4'h0, 1'b0, 16'hFFFE, 16'h0, 1'b0, 2'd0);
        step(1'b0, 4'd0, 4'h0, 1'b0, 16'h0, 16'h0, 1'b1, 2'd3);
        check("R10", 32'(pc), 32'h0001);

        // load beats increment, both sources: R8 R9
        step(1'b1, 4'd9, 4'h0, 1'b1, 16'h1111, 16'hA5A5, 1'b1, 2'd3);
        step(1'b1, 4'd5, 4'h0, 1'b0, 16'h5A5A, 16'h2222, 1'b1, 2'd2);

        // constrained random cycles
        for (int i = 0; i < 3000; i++) begin
            logic v;
            logic [3:0] code;
            v = ($urandom_range(0, 9) != 0);
            code = ($urandom_range(0, 7) == 0) ? 4'($urandom_range(10, 15))
                                               : 4'($urandom_range(0, 9));
            step(v, code, 4'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
                 1'($urandom), 2'($urandom));
            if (i == 1500) do_reset();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule